// File: doc/BRIEF.md
# Split-Rate SPI Master

This block is an SPI master that software drives through three word-wide registers: a data word, a transfer setup word and a configuration word. Each transfer has two phases. The write phase shifts bits out on MOSI. The read phase that follows samples bits in. Each phase takes its serial clock from its own divider of the system clock, so a slow device response can be read at a lower rate than the command is sent, or the reverse.

The setup word selects the chip-select lines and sets the bit count of each phase. A write to the data register starts a transfer. A data word written while a transfer is running is held as pending. It starts the moment the running transfer's last bit ends, so chip select stays low across the chained transfers. The word received in the read phase is read back from the data address. The configuration word reads back with two live status bits, active and pending. A register write closes the write port for one cycle.

Top module: `spi_split_master`

## Requirements
- R1: After reset every chip-select line is high (inactive), SCK is low, regReady is 1, both output enables are 1, and reads of the configuration address (2) and the data address (0) return 0.
- R2: During the write phase, the data word (address 0) is shifted out on MOSI, one bit per write-bit period. The MSB goes first when configuration bit 5 is 0, and the LSB goes first when it is 1. Each bit is stable at the SCK edge that falls in the middle of its bit period.
- R3: The read phase takes one sample per bit at the mid-bit SCK edge and shifts it into the LSB end of a word. That word is cleared when a transfer starts. After the transfer ends, it can be read from address 0. With a read count of n, the first bit sampled ends up at bit n-1.
- R4: A write bit lasts configuration[23:16]+2 system clocks and a read bit lasts configuration[31:24]+2. The idle level of SCK is configuration bit 3. Configuration bit 4 selects where SCK sits in each bit: when it is 0, SCK is at the idle level in the first half; when it is 1, SCK is at the idle level in the second half.
- R5: While chip select is asserted, csN equals the inverse of setup word bits [15:0]. The write bit count is in setup[23:16] and the read bit count is in setup[31:24]. When configuration bit 7 (end) is set, chip select stays low for 2*floor(wdiv/2) + wlen*wdiv + rlen*rdiv cycles.
- R6: A data word written while a transfer is active sets the pending bit (configuration read bit 2). The pending word starts on the cycle after the last bit of the running transfer, with no setup or hold gap, and chip select stays low throughout.
- R7: When configuration bit 7 is 0, chip select stays low after the transfer finishes, and the active bit (configuration read bit 1) returns to 0.
- R8: regReady is 0 in the cycle that follows an accepted register write. A write presented in that cycle is ignored.
- R9: The configuration register reads back the bits that were written, with bit 1 replaced by active and bit 2 replaced by pending.
- R10: Configuration bit 0 (offline) drives outEn and mosiOe to 0.
- R11: When configuration bit 6 (half-duplex) is set, the read phase samples mosiIn instead of miso, and mosiOe is 0 for every read-phase cycle.
- R12: A data write that arrives while a pending word is already held is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address: 0 data, 1 setup, 2 configuration |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; regRdata is valid on the following cycle |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| regReady | output | 1 | Write port open |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Enable for the MOSI driver |
| miso | input | 1 | Serial data in |
| mosiIn | input | 1 | Data-line input used in half-duplex reads |
| csN | output | NCS | Active-low chip selects |
| outEn | output | 1 | Enable for the SCK and chip-select drivers |

## Verification
A wrong bit counter or a wrong divider choice changes how long chip select stays low, and that shows up as soon as the transfer ends. A wrong shift direction or a wrong phase boundary corrupts the word captured from MOSI, or the word read back from address 0, within that same transfer. A lost or stale pending flag either leaves a gap in chip select or drops the chained bits. A read of configuration bit 2 exposes it while the first transfer is still running.

// File: rtl/spi_split_pkg.sv
`timescale 1ns/1ps
package spi_split_pkg;

  localparam int DATA_W = 32;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_XFER = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  localparam int F_OFFLINE = 0;
  localparam int F_ACTIVE  = 1;
  localparam int F_PENDING = 2;
  localparam int F_CPOL    = 3;
  localparam int F_CPHA    = 4;
  localparam int F_LSB     = 5;
  localparam int F_HALFDX  = 6;
  localparam int F_END     = 7;

  localparam int WDIV_LSB = 16;
  localparam int RDIV_LSB = 24;
  localparam int WLEN_LSB = 16;
  localparam int RLEN_LSB = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BITS,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic loadTx;
    logic loadNext;
    logic storeNext;
    logic shiftTx;
    logic sampleBit;
    logic clrRx;
    logic latchRx;
  } dpCmd_t;

endpackage

// File: rtl/spi_split_dp.sv
`timescale 1ns/1ps
module spi_split_dp
  import spi_split_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [DW-1:0] wrData,
  input  logic          lsbFirst,
  input  logic          rxBit,
  output logic          txBit,
  output logic [DW-1:0] rxWord
);

  logic [DW-1:0] txShift;
  logic [DW-1:0] txNext;
  logic [DW-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      txNext  <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (cmd.loadTx)        txShift <= wrData;
      else if (cmd.loadNext) txShift <= txNext;
      else if (cmd.shiftTx)  txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);

      if (cmd.storeNext) txNext <= wrData;

      if (cmd.clrRx)          rxShift <= '0;
      else if (cmd.sampleBit) rxShift <= {rxShift[DW-2:0], rxBit};

      if (cmd.latchRx) rxWord <= rxShift;
    end
  end

  assign txBit = lsbFirst ? txShift[0] : txShift[DW-1];

  // R3: a cleared receive word starts empty on the next cycle
  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrRx |=> (rxShift == '0));

  // R2: the transmit word is loaded or shifted by at most one source per cycle
  assert_tx_single_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadTx, cmd.loadNext, cmd.shiftTx}));

endmodule

// File: rtl/spi_split_ctrl.sv
`timescale 1ns/1ps
module spi_split_ctrl
  import spi_split_pkg::*;
#(
  parameter int NCS   = 16,
  parameter int LEN_W = 8,
  parameter int DIV_W = 8,
  parameter int DW    = DATA_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     regAddr,
  input  logic           regWr,
  input  logic           regRd,
  input  logic [DW-1:0]  regWdata,
  output logic [DW-1:0]  regRdata,
  output logic           regReady,
  input  logic [DW-1:0]  rxWord,
  input  logic           txBit,
  input  logic           miso,
  input  logic           mosiIn,
  output dpCmd_t         cmd,
  output logic           lsbFirst,
  output logic           rxBit,
  output logic           sck,
  output logic           mosi,
  output logic           mosiOe,
  output logic           outEn,
  output logic [NCS-1:0] csN
);

  localparam int CNT_W = DIV_W + 1;
  localparam int IDX_W = LEN_W + 1;

  logic [15:0]      cfgLow;
  logic [DIV_W-1:0] wDivM2, rDivM2;
  logic [15:0]      csMask;
  logic [LEN_W-1:0] wLen, rLen;

  logic wrGap, wrOk, dataWr;

  seqState_t        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             secondHalf, csActive, pending;

  logic [CNT_W-1:0] wDiv, rDiv, halfW, firstDiv, curDiv, nextDiv;
  logic [IDX_W-1:0] total, nextIdx;
  logic             curIsWrite, nextIsWrite, lastBit;
  logic             bitMid, bitEnd, chainNow;
  logic             cpol, cpha, halfDx, endFlag, offline;

  assign offline  = cfgLow[F_OFFLINE];
  assign cpol     = cfgLow[F_CPOL];
  assign cpha     = cfgLow[F_CPHA];
  assign lsbFirst = cfgLow[F_LSB];
  assign halfDx   = cfgLow[F_HALFDX];
  assign endFlag  = cfgLow[F_END];

  assign wrOk     = regWr && !wrGap;
  assign regReady = !wrGap;
  assign dataWr   = wrOk && (regAddr == ADDR_DATA);

  assign wDiv  = {1'b0, wDivM2} + CNT_W'(2);
  assign rDiv  = {1'b0, rDivM2} + CNT_W'(2);
  assign halfW = wDiv >> 1;

  assign total       = {1'b0, wLen} + {1'b0, rLen};
  assign nextIdx     = bitIdx + IDX_W'(1);
  assign curIsWrite  = bitIdx  < {1'b0, wLen};
  assign nextIsWrite = nextIdx < {1'b0, wLen};
  assign lastBit     = (nextIdx == total);
  assign firstDiv    = (wLen != '0) ? wDiv : rDiv;
  assign curDiv      = curIsWrite  ? wDiv : rDiv;
  assign nextDiv     = nextIsWrite ? wDiv : rDiv;

  assign bitMid   = (st == ST_BITS) && (cnt == '0) && !secondHalf;
  assign bitEnd   = (st == ST_BITS) && (cnt == '0) &&  secondHalf;
  assign chainNow = bitEnd && lastBit && pending && (total != '0);

  // Register file and write-port spacing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLow <= '0;
      wDivM2 <= '0;
      rDivM2 <= '0;
      csMask <= '0;
      wLen   <= '0;
      rLen   <= '0;
      wrGap  <= 1'b0;
    end else begin
      wrGap <= wrOk;
      if (wrOk) begin
        case (regAddr)
          ADDR_XFER: begin
            csMask <= regWdata[15:0];
            wLen   <= regWdata[WLEN_LSB +: LEN_W];
            rLen   <= regWdata[RLEN_LSB +: LEN_W];
          end
          ADDR_CFG: begin
            cfgLow <= regWdata[15:0] & ~16'h0006;
            wDivM2 <= regWdata[WDIV_LSB +: DIV_W];
            rDivM2 <= regWdata[RDIV_LSB +: DIV_W];
          end
          default: ;
        endcase
      end
    end
  end

  // Registered read-back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (regRd) begin
      case (regAddr)
        ADDR_DATA: regRdata <= rxWord;
        ADDR_XFER: regRdata <= {rLen, wLen, csMask};
        ADDR_CFG:  regRdata <= {rDivM2, wDivM2, cfgLow[15:3], pending,
                                (st != ST_IDLE), cfgLow[F_OFFLINE]};
        default:   regRdata <= '0;
      endcase
    end
  end

  // Transfer sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      bitIdx     <= '0;
      secondHalf <= 1'b0;
      csActive   <= 1'b0;
      pending    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (pending || dataWr) begin
            st         <= ST_SETUP;
            cnt        <= halfW - CNT_W'(1);
            csActive   <= 1'b1;
            bitIdx     <= '0;
            secondHalf <= 1'b0;
            pending    <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (total == '0) begin
            st  <= ST_HOLD;
            cnt <= halfW - CNT_W'(1);
          end else begin
            st         <= ST_BITS;
            cnt        <= (firstDiv >> 1) - CNT_W'(1);
            secondHalf <= 1'b0;
          end
        end
        ST_BITS: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!secondHalf) begin
            secondHalf <= 1'b1;
            cnt        <= curDiv - (curDiv >> 1) - CNT_W'(1);
          end else if (!lastBit) begin
            bitIdx     <= nextIdx;
            secondHalf <= 1'b0;
            cnt        <= (nextDiv >> 1) - CNT_W'(1);
          end else if (chainNow) begin
            bitIdx     <= '0;
            secondHalf <= 1'b0;
            cnt        <= (firstDiv >> 1) - CNT_W'(1);
            pending    <= 1'b0;
          end else begin
            st  <= ST_HOLD;
            cnt <= halfW - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            st <= ST_IDLE;
            if (endFlag) csActive <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (dataWr && (st != ST_IDLE) && !pending) pending <= 1'b1;
    end
  end

  // Strobes to the datapath
  always_comb begin
    cmd           = '0;
    cmd.loadTx    = (st == ST_IDLE) && !pending && dataWr;
    cmd.loadNext  = ((st == ST_IDLE) && pending) || chainNow;
    cmd.storeNext = dataWr && (st != ST_IDLE) && !pending;
    cmd.shiftTx   = bitEnd && !lastBit && curIsWrite;
    cmd.sampleBit = bitMid && !curIsWrite;
    cmd.clrRx     = cmd.loadTx || cmd.loadNext;
    cmd.latchRx   = (bitEnd && lastBit) ||
                    ((st == ST_SETUP) && (cnt == '0) && (total == '0));
  end

  assign rxBit  = halfDx ? mosiIn : miso;
  assign sck    = cpol ^ ((st == ST_BITS) && (cpha ? !secondHalf : secondHalf));
  assign mosi   = ((st == ST_SETUP) || (st == ST_BITS)) && curIsWrite && txBit;
  assign outEn  = !offline;
  assign mosiOe = !offline && !(halfDx && (st == ST_BITS) && !curIsWrite);
  assign csN    = csActive ? ~csMask[NCS-1:0] : '1;

  // R4: a half-bit does not flip before its count runs out
  assert_half_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_BITS) && (cnt != '0)) |=> $stable(secondHalf));

  // R5: bits are never shifted with chip select released
  assert_cs_during_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_BITS) |-> csActive);

  // R6: a word only becomes pending behind a running transfer
  assert_pending_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> ($past(st) != ST_IDLE));

  // R8: two writes are never accepted on adjacent cycles
  assert_write_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |=> !wrOk);

endmodule

// File: rtl/spi_split_master.sv
`timescale 1ns/1ps
module spi_split_master
  import spi_split_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     regAddr,
  input  logic           regWr,
  input  logic           regRd,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  output logic           regReady,
  output logic           sck,
  output logic           mosi,
  output logic           mosiOe,
  input  logic           miso,
  input  logic           mosiIn,
  output logic [NCS-1:0] csN,
  output logic           outEn
);

  dpCmd_t            cmd;
  logic              lsbFirst, rxBit, txBit;
  logic [DATA_W-1:0] rxWord;

  spi_split_ctrl #(.NCS(NCS), .LEN_W(8), .DIV_W(8), .DW(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .regReady (regReady),
    .rxWord   (rxWord),
    .txBit    (txBit),
    .miso     (miso),
    .mosiIn   (mosiIn),
    .cmd      (cmd),
    .lsbFirst (lsbFirst),
    .rxBit    (rxBit),
    .sck      (sck),
    .mosi     (mosi),
    .mosiOe   (mosiOe),
    .outEn    (outEn),
    .csN      (csN)
  );

  spi_split_dp #(.DW(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wrData   (regWdata),
    .lsbFirst (lsbFirst),
    .rxBit    (rxBit),
    .txBit    (txBit),
    .rxWord   (rxWord)
  );

endmodule

// File: tb/sim_spi_split_master.sv
`timescale 1ns/1ps
module sim_spi_split_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regReady, sck, mosi, mosiOe, outEn;
  logic        misoTb, mosiInTb;
  logic [15:0] csN;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  spi_split_master #(.NCS(16)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady),
    .sck(sck), .mosi(mosi), .mosiOe(mosiOe), .miso(misoTb), .mosiIn(mosiInTb),
    .csN(csN), .outEn(outEn)
  );

  // Slave model settings, set by the stimulus
  logic        sCpol = 1'b0, sCpha = 1'b0, hdMode = 1'b0;
  int          sWlen = 0, sRlen = 0, eBase = 0;
  logic [31:0] sPat = '0;

  // Slave model state, owned by the edge process
  int          eCnt = 0;
  logic [31:0] capAll = '0;

  function automatic logic slvBit(int e);
    int r;
    r = e - eBase - sWlen;
    if (r >= 0 && r < sRlen) return sPat[sRlen - 1 - r];
    return 1'b0;
  endfunction

  assign mosiInTb = slvBit(eCnt);
  assign misoTb   = hdMode ? ~slvBit(eCnt) : slvBit(eCnt);

  always @(sck) begin
    if (csN != '1 && sck == (sCpha ? sCpol : ~sCpol)) begin
      if (eCnt - eBase < sWlen) capAll = {capAll[30:0], mosi};
      eCnt = eCnt + 1;
    end
  end

  // Line monitor
  int          csLowTot = 0, oeLowTot = 0;
  logic [15:0] csVal = '1;
  always @(negedge clk) begin
    if (csN != '1) begin
      csLowTot = csLowTot + 1;
      csVal = csN;
      if (!mosiOe) oeLowTot = oeLowTot + 1;
    end
  end

  typedef struct packed {
    logic [7:0]  flags;
    logic [7:0]  wM2;
    logic [7:0]  rM2;
    logic [7:0]  wLen;
    logic [7:0]  rLen;
    logic [15:0] cs;
    logic [31:0] data;
    logic [31:0] pat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h80, 8'd0, 8'd0, 8'd8,  8'd8,  16'h0001, 32'hA5000000, 32'h0000003C},
    '{8'h98, 8'd2, 8'd5, 8'd12, 8'd5,  16'h0004, 32'h12345678, 32'h00000015},
    '{8'hA0, 8'd1, 8'd0, 8'd16, 8'd16, 16'h8000, 32'h0000BEEF, 32'h0000C0DE},
    '{8'h90, 8'd0, 8'd3, 8'd0,  8'd32, 16'h0003, 32'h00000000, 32'hDEADBEEF},
    '{8'h88, 8'd4, 8'd0, 8'd32, 8'd0,  16'h0010, 32'hF00DCAFE, 32'h00000000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  function automatic logic [31:0] lowMask(int n);
    if (n >= 32) return '1;
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic waitCsHigh(input int base);
    int guard;
    guard = 0;
    while ((csLowTot == base || csN != '1) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check("R5", "chip select released", {31'd0, guard < 5000}, 32'd1);
  endtask

  task automatic runXfer(input vec_t v, input logic useHd);
    int csBase, oeBase, wd, rd, expLow;
    logic [31:0] expTx, rdv;
    regWrite(2'd2, {v.rM2, v.wM2, 8'h00, v.flags});
    regWrite(2'd1, {v.rLen, v.wLen, v.cs});
    sCpol = v.flags[3]; sCpha = v.flags[4]; hdMode = useHd;
    sWlen = int'(v.wLen); sRlen = int'(v.rLen); sPat = v.pat;
    eBase = eCnt; csBase = csLowTot; oeBase = oeLowTot;
    regWrite(2'd0, v.data);
    waitCsHigh(csBase);
    expTx = '0;
    for (int i = 0; i < int'(v.wLen); i++)
      expTx = {expTx[30:0], v.flags[5] ? v.data[i] : v.data[31 - i]};
    check("R2", "MOSI word", capAll & lowMask(sWlen), expTx);
    regRead(2'd0, rdv);
    check(useHd ? "R11" : "R3", "received word", rdv, v.pat & lowMask(sRlen));
    wd = int'(v.wM2) + 2; rd = int'(v.rM2) + 2;
    expLow = 2 * (wd / 2) + sWlen * wd + sRlen * rd;
    check("R4", "chip-select low cycles", csLowTot - csBase, expLow);
    check("R5", "chip-select pattern", {16'd0, csVal}, {16'd0, ~v.cs});
    check("R4", "SCK idle level", {31'd0, sck}, {31'd0, v.flags[3]});
    if (useHd) check("R11", "mosiOe low cycles", oeLowTot - oeBase, sRlen * rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R5: actual run not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int base;
    vec_t hv;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "csN", {16'd0, csN}, 32'h0000FFFF);
    check("R1", "sck", {31'd0, sck}, 32'd0);
    check("R1", "regReady", {31'd0, regReady}, 32'd1);
    check("R1", "enables", {30'd0, outEn, mosiOe}, 32'd3);
    regRead(2'd2, rv); check("R1", "config read", rv, 32'd0);
    regRead(2'd0, rv); check("R1", "data read", rv, 32'd0);

    // Table of transfers: R2 R3 R4 R5
    for (int i = 0; i < 5; i++) runXfer(VECS[i], 1'b0);

    // R11: half-duplex read phase from mosiIn, MOSI driver off
    hv = '{8'hC0, 8'd0, 8'd1, 8'd4, 8'd8, 16'h0001, 32'h90000000, 32'h0000005A};
    runXfer(hv, 1'b1);
    hdMode = 1'b0;

    // R8: write in the cycle after an accepted write is ignored
    @(negedge clk);
    regAddr = 2'd1; regWdata = 32'h0408_0001; regWr = 1'b1;
    @(negedge clk);
    check("R8", "regReady after write", {31'd0, regReady}, 32'd0);
    regWdata = 32'h0102_0002;
    @(negedge clk);
    regWr = 1'b0;
    @(negedge clk);
    regRead(2'd1, rv); check("R8", "setup word kept", rv, 32'h0408_0001);

    // R9 R10: offline and config read-back
    regWrite(2'd2, 32'h0302_0079);
    check("R10", "enables offline", {30'd0, outEn, mosiOe}, 32'd0);
    regRead(2'd2, rv); check("R9", "config read-back", rv, 32'h0302_0079);

    // R6 R12: chained transfers, extra word ignored
    regWrite(2'd2, 32'h0000_0080);
    regWrite(2'd1, {8'd0, 8'd8, 16'h0001});
    sCpol = 1'b0; sCpha = 1'b0; sWlen = 16; sRlen = 0; sPat = '0;
    eBase = eCnt; base = csLowTot;
    regWrite(2'd0, 32'hC3000000);
    regWrite(2'd0, 32'h5A000000);
    regRead(2'd2, rv); check("R6", "active and pending bits", rv, 32'h0000_0086);
    regWrite(2'd0, 32'hFF000000);
    waitCsHigh(base);
    check("R6", "chained MOSI bits", capAll & 32'h0000FFFF, 32'h0000C35A);
    check("R12", "chained low cycles", csLowTot - base, 34);

    // R7: no end flag keeps chip select low
    regWrite(2'd2, 32'h0000_0000);
    regWrite(2'd1, {8'd0, 8'd4, 16'h0002});
    sWlen = 4; eBase = eCnt;
    regWrite(2'd0, 32'hA0000000);
    repeat (30) @(negedge clk);
    check("R7", "chip select held", {16'd0, csN}, 32'h0000FFFD);
    regRead(2'd2, rv); check("R7", "active bit clear", rv, 32'd0);
    regWrite(2'd2, 32'h0000_0080);
    base = csLowTot; eBase = eCnt;
    regWrite(2'd0, 32'h50000000);
    waitCsHigh(base);
    check("R7", "released after end transfer", {16'd0, csN}, 32'h0000FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule